// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block drives and observes a bank of general-purpose pins through a small word-addressed register port. Software sets a per-pin output value and a per-pin output enable. It reads back the pad levels after they have crossed into the clock domain, and it arms pins to report interrupts.

Each pin has a detector. The detector watches the synchronised pad for a low level, a high level, a rising edge or a falling edge, chosen by a 2-bit trigger code. A separate per-pin override makes the pin react to both edges. A detected event latches a sticky status bit. Software clears that bit by writing a one to its position.

Masked status bits are combined into two interrupt lines. One line covers the lower half of the pins and the other covers the upper half, so each half can be routed to its own interrupt controller input.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Writing word 0 sets the output latch driven on `pad_out`, and reading word 0 returns that latch. Writing word 1 sets the direction register: a 1 in bit n enables the driver of pin n on `pad_oe[n]`, and a 0 makes pin n an input.
- R2: The port answers a request by raising `bus_ready` for exactly one cycle, in the cycle after `bus_valid` is first seen high. The access takes effect at the clock edge where `bus_valid` and `bus_ready` are both high. Read data is valid on `bus_rdata` while `bus_ready` is high.
- R3: Pads pass through two flip-flops. Reading word 2 returns the synchronised pad values, and writes to word 2 have no effect. An edge that reaches the pad before clock edge k sets its status bit at edge k+2, and the interrupt line rises after that edge.
- R4: The trigger code for pin n sits at bits [2n+1:2n] of word 3 when n < 16, and at bits [2(n-16)+1:2(n-16)] of word 4 when n >= 16. The codes are: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R5: When bit n of word 7 (the both-edges register) is 1, pin n fires on either edge and its trigger code has no effect.
- R6: The status register is word 6. Its bits stay set until cleared. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A bit whose event is active in the same cycle as the clear stays set, so a level trigger whose level persists sets its bit again.
- R7: Word 5 is the mask. `irq_lo` is the OR of status AND mask over pins 0-15, and `irq_hi` is the same over pins 16-31. A status bit whose mask bit is 0 drives neither line.
- R8: After reset the data, direction, trigger, mask and both-edges registers are all zero, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
The bench uses the default of 32 pins and two synchroniser stages. This is the only configuration in which both trigger words are fully populated. With it, a field placed in the upper trigger word can be shown to act on pin 20 only, and pin 20 can be shown to raise `irq_hi` while `irq_lo` stays quiet. The two-stage depth fixes the edge-to-interrupt latency at three clock edges, and the bench checks that latency cycle by cycle. The default also lets level retriggering, partial write-one-to-clear and the both-edges override run on separate pins in the same run.

// File: rtl/gpio_pkg.sv
// Shared definitions for the pin controller: register word indices and
// trigger codes. Assumes word-indexed addressing (byte offset / 4).
package gpio_pkg;
    typedef enum logic [2:0] {
        RG_DATA    = 3'd0,
        RG_DIR     = 3'd1,
        RG_PAD     = 3'd2,
        RG_TRIG_LO = 3'd3,
        RG_TRIG_HI = 3'd4,
        RG_MASK    = 3'd5,
        RG_STAT    = 3'd6,
        RG_BOTH    = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        TRG_LOW  = 2'd0,
        TRG_HIGH = 2'd1,
        TRG_RISE = 2'd2,
        TRG_FALL = 2'd3
    } trig_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift pad values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
// Per-pin event detector. Compares each synchronised level with its value
// one clock earlier and applies the pin's trigger code or both-edges override.
// Assumes trig_cfg packs pin p's code at bits [2p+1:2p].
module gpio_detect
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PINS-1:0]     level,
    input  logic [2*N_PINS-1:0]   trig_cfg,
    input  logic [N_PINS-1:0]     both_edges,
    output logic [N_PINS-1:0]     evt
);
    logic [N_PINS-1:0] prev_q;

    // Hold last cycle's synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        trig_e code;
        assign code = trig_e'(trig_cfg[2*p +: 2]);

        // Decode this pin's event from its level, history and trigger code.
        always_comb begin
            if (both_edges[p]) begin
                evt[p] = level[p] ^ prev_q[p];
            end else begin
                unique case (code)
                    TRG_LOW:  evt[p] = ~level[p];
                    TRG_HIGH: evt[p] = level[p];
                    TRG_RISE: evt[p] = level[p] & ~prev_q[p];
                    default:  evt[p] = ~level[p] & prev_q[p];
                endcase
            end
        end

        a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[p] && !both_edges[p] && code == TRG_RISE) |-> (level[p] && !$past(level[p])));
        a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[p] && !both_edges[p] && code == TRG_FALL) |-> (!level[p] && $past(level[p])));
        a_r5_both_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[p] && both_edges[p]) |-> (level[p] != $past(level[p])));
    end
endmodule

// File: rtl/gpio_regs.sv
// Register file: output latch, direction, trigger words, mask, both-edges
// and sticky write-one-to-clear status. Assumes REG_W >= N_PINS.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS = 32,
    parameter int unsigned REG_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          sel,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic [N_PINS-1:0]   pad_sync,
    input  logic [N_PINS-1:0]   evt,
    output logic [N_PINS-1:0]   data_q,
    output logic [N_PINS-1:0]   dir_q,
    output logic [2*N_PINS-1:0] trig_cfg,
    output logic [N_PINS-1:0]   mask_q,
    output logic [N_PINS-1:0]   stat_q,
    output logic [N_PINS-1:0]   both_q
);
    localparam int unsigned HALF   = N_PINS / 2;
    localparam int unsigned TRIG_W = 2 * HALF;

    logic [TRIG_W-1:0] trig_lo_q, trig_hi_q;
    logic [N_PINS-1:0] wr_pins, clr;

    assign wr_pins  = wr_data[N_PINS-1:0];
    assign trig_cfg = {trig_hi_q, trig_lo_q};
    assign clr      = (wr_en && sel == RG_STAT) ? wr_pins : '0;

    // Software-writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            dir_q     <= '0;
            trig_lo_q <= '0;
            trig_hi_q <= '0;
            mask_q    <= '0;
            both_q    <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(sel))
                RG_DATA:    data_q    <= wr_pins;
                RG_DIR:     dir_q     <= wr_pins;
                RG_TRIG_LO: trig_lo_q <= wr_data[TRIG_W-1:0];
                RG_TRIG_HI: trig_hi_q <= wr_data[TRIG_W-1:0];
                RG_MASK:    mask_q    <= wr_pins;
                RG_BOTH:    both_q    <= wr_pins;
                default:    ;
            endcase
        end
    end

    // Sticky status: clear by written ones, new events win over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | evt;
    end

    // Read-back multiplexer.
    always_comb begin
        unique case (reg_sel_e'(sel))
            RG_DATA:    rd_data = REG_W'(data_q);
            RG_DIR:     rd_data = REG_W'(dir_q);
            RG_PAD:     rd_data = REG_W'(pad_sync);
            RG_TRIG_LO: rd_data = REG_W'(trig_lo_q);
            RG_TRIG_HI: rd_data = REG_W'(trig_hi_q);
            RG_MASK:    rd_data = REG_W'(mask_q);
            RG_STAT:    rd_data = REG_W'(stat_q);
            default:    rd_data = REG_W'(both_q);
        endcase
    end

    a_r6_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));
    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((~stat_q & $past(stat_q & ~clr)) == '0));
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RG_STAT) |=> ((stat_q & $past(wr_pins & ~evt)) == '0));
    a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RG_DIR) |=> (dir_q == $past(wr_pins)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the pin controller. Handles the valid/ready register port,
// instantiates synchroniser, detectors and registers, and forms the two
// half-bank interrupt lines. Assumes N_PINS is even and fits in REG_W.
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS      = 32,
    parameter int unsigned REG_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [2:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              bus_ready,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int unsigned HALF = N_PINS / 2;

    logic                  ready_q;
    logic                  wr_en;
    logic [REG_W-1:0]      rd_data;
    logic [N_PINS-1:0]     pad_sync, evt, mask_q, stat_q, both_q, pending;
    logic [2*N_PINS-1:0]   trig_cfg;

    // Acknowledge each request with a single-cycle ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= bus_valid && !ready_q;
    end

    assign bus_ready = ready_q;
    assign wr_en     = bus_valid && ready_q && bus_write;
    assign bus_rdata = ready_q ? rd_data : '0;

    gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_detect #(.N_PINS(N_PINS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (pad_sync),
        .trig_cfg   (trig_cfg),
        .both_edges (both_q),
        .evt        (evt)
    );

    gpio_regs #(.N_PINS(N_PINS), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (bus_addr),
        .wr_data  (bus_wdata),
        .rd_data  (rd_data),
        .pad_sync (pad_sync),
        .evt      (evt),
        .data_q   (pad_out),
        .dir_q    (pad_oe),
        .trig_cfg (trig_cfg),
        .mask_q   (mask_q),
        .stat_q   (stat_q),
        .both_q   (both_q)
    );

    // Gate status with the mask and reduce each half to its line.
    assign pending = stat_q & mask_q;
    assign irq_lo  = |pending[HALF-1:0];
    assign irq_hi  = |pending[N_PINS-1:HALF];

    a_r2_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    a_r2_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> $past(bus_valid));
    a_r7_lo_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[HALF-1:0] == '0) |-> !irq_lo);
    a_r7_hi_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[N_PINS-1:HALF] == '0) |-> !irq_hi);
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        bus_wr(3'd6, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R8 irq_lo after reset", {31'd0, irq_lo}, 32'd0);
        chk("R8 irq_hi after reset", {31'd0, irq_hi}, 32'd0);
        chk("R8 pad_oe after reset", pad_oe, 32'd0);
        chk("R8 pad_out after reset", pad_out, 32'd0);
        bus_rd(3'd5, v); chk("R8 mask after reset", v, 32'd0);
        bus_rd(3'd7, v); chk("R8 both-edges after reset", v, 32'd0);
        bus_rd(3'd3, v); chk("R8 trigger lo after reset", v, 32'd0);
        // low-level code 0 with low pads: every status bit latched (R4)
        bus_rd(3'd6, v); chk("R4 low level sets all status", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_handshake();
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd0;
        chk("R2 ready low before edge", {31'd0, bus_ready}, 32'd0);
        @(posedge clk); #1;
        chk("R2 ready high one cycle later", {31'd0, bus_ready}, 32'd1);
        @(negedge clk);
        @(posedge clk); #1;
        chk("R2 ready is one cycle only", {31'd0, bus_ready}, 32'd0);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic t_data_dir();
        logic [31:0] v;
        bus_wr(3'd0, 32'hA5A5_0F0F);
        chk("R1 pad_out follows data", pad_out, 32'hA5A5_0F0F);
        bus_rd(3'd0, v); chk("R1 data readback", v, 32'hA5A5_0F0F);
        bus_wr(3'd1, 32'h0000_FFFF);
        chk("R1 pad_oe follows direction", pad_oe, 32'h0000_FFFF);
        bus_rd(3'd1, v); chk("R1 direction readback", v, 32'h0000_FFFF);
    endtask

    task automatic t_pad_read();
        logic [31:0] v;
        bus_wr(3'd3, 32'h5555_5555);  // all high-level
        bus_wr(3'd4, 32'h5555_5555);
        @(negedge clk); pad_in = 32'h1234_8001;
        settle(3);
        bus_rd(3'd2, v); chk("R3 pad status synchronised", v, 32'h1234_8001);
        bus_wr(3'd2, 32'hFFFF_FFFF);
        bus_rd(3'd2, v); chk("R3 pad status ignores writes", v, 32'h1234_8001);
        @(negedge clk); pad_in = '0;
        settle(3);
        clear_all();
        bus_rd(3'd6, v); chk("R6 all cleared with ones", v, 32'd0);
    endtask

    task automatic t_rise_latency();
        logic [31:0] v;
        bus_wr(3'd3, 32'h5555_5595);  // pin 3 rising
        bus_wr(3'd5, 32'h0000_0008);
        clear_all();
        pad_in[3] = 1'b1;             // at negedge before edge k
        @(posedge clk); #1;
        chk("R3 no irq at edge k", {31'd0, irq_lo}, 32'd0);
        @(posedge clk); #1;
        chk("R3 no irq at edge k+1", {31'd0, irq_lo}, 32'd0);
        @(posedge clk); #1;
        chk("R3 irq_lo after edge k+2", {31'd0, irq_lo}, 32'd1);
        @(negedge clk);
        clear_all();
        settle(3);
        chk("R4 rising fires once", {31'd0, irq_lo}, 32'd0);
        pad_in[3] = 1'b0;
        settle(4);
        bus_rd(3'd6, v); chk("R4 falling ignored by rise code", v & 32'h8, 32'd0);
        bus_wr(3'd5, 32'd0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        bus_wr(3'd3, 32'h5555_D555);  // pin 7 falling, bits [15:14]
        pad_in[7] = 1'b1;
        settle(4);
        clear_all();
        bus_rd(3'd6, v); chk("R4 rise ignored by fall code", v & 32'h80, 32'd0);
        pad_in[7] = 1'b0;
        settle(4);
        bus_rd(3'd6, v); chk("R4 falling edge sets bit 7", v & 32'h80, 32'h80);
        clear_all();
    endtask

    task automatic t_halves();
        logic [31:0] v;
        bus_wr(3'd3, 32'h5555_5555);
        bus_wr(3'd4, 32'h5555_5655);  // pin 20 rising at word 4 bits [9:8]
        clear_all();
        pad_in[20] = 1'b1;
        settle(4);
        bus_rd(3'd6, v); chk("R4 upper-word field on pin 20", v, 32'h0010_0000);
        chk("R7 masked pin drives no irq_hi", {31'd0, irq_hi}, 32'd0);
        bus_wr(3'd5, 32'h0010_0000);
        chk("R7 irq_hi once unmasked", {31'd0, irq_hi}, 32'd1);
        chk("R7 irq_lo stays low", {31'd0, irq_lo}, 32'd0);
        clear_all();
        chk("R7 irq_hi drops after clear", {31'd0, irq_hi}, 32'd0);
        pad_in[20] = 1'b0;
        bus_wr(3'd5, 32'd0);
        bus_wr(3'd4, 32'h5555_5555);
        settle(3);
        clear_all();
    endtask

    task automatic t_both_edges();
        logic [31:0] v;
        bus_wr(3'd3, 32'h5551_5555);  // pin 9 low-level code, overridden
        bus_wr(3'd7, 32'h0000_0200);
        clear_all();
        settle(4);
        bus_rd(3'd6, v); chk("R5 low code ignored under both-edges", v & 32'h200, 32'd0);
        pad_in[9] = 1'b1;
        settle(4);
        bus_rd(3'd6, v); chk("R5 rise detected", v & 32'h200, 32'h200);
        clear_all();
        pad_in[9] = 1'b0;
        settle(4);
        bus_rd(3'd6, v); chk("R5 fall detected", v & 32'h200, 32'h200);
        bus_wr(3'd7, 32'd0);
        bus_wr(3'd3, 32'h5555_5555);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pad_in[12] = 1'b1;
        pad_in[13] = 1'b1;
        settle(4);
        pad_in[13] = 1'b0;
        settle(4);
        bus_rd(3'd6, v); chk("R6 sticky after level gone", v, 32'h0000_3000);
        bus_wr(3'd6, 32'h0000_1000);
        bus_rd(3'd6, v); chk("R6 level retriggers, zero bit untouched", v, 32'h0000_3000);
        bus_wr(3'd6, 32'h0000_2000);
        bus_rd(3'd6, v); chk("R6 only written bit cleared", v, 32'h0000_1000);
        pad_in[12] = 1'b0;
        settle(4);
        clear_all();
        bus_rd(3'd6, v); chk("R6 cleared after level removed", v, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        settle(2);
        t_reset();
        t_handshake();
        t_data_dir();
        t_pad_read();
        t_rise_latency();
        t_fall();
        t_halves();
        t_both_edges();
        t_w1c();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule